// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps the time of day and the calendar date as BCD digits: seconds, minutes and hours in 24-hour form, a day-of-week code, day of month, month and a four-digit year. A strobe at 4096 Hz enters a sub-second divider. The divider produces one seconds advance per `TICKS_PER_SEC` strobes. Carries ripple from seconds through minutes, hours, the day-of-week and date, the month and the year. Month lengths and 29 February are handled without help from the host.

The host sees sixteen nibble-wide locations. It can load any single digit through a write port and read any digit through a registered read port. One control location has three jobs. It holds a stop bit, which freezes time and clears the divider. It accepts a request to round to the nearest minute. When read, it returns a busy flag that warns the host not to sample the digits while they may be changing.

The busy flag covers the last strobe period before every seconds advance. It also stays high from the moment a rounding request is accepted until the request is carried out on the next strobe.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the counter reads 2000-01-01, day code 6, 00:00:00. Stop is 0, no rounding request is pending, and `rd_data` is 0.
- R2: Seconds advance by one on every `TICKS_PER_SEC`-th strobe of `tick_4k`, counted from the last divider clear. Cycles without a strobe do not count. Seconds carry from 59 into minutes, minutes carry from 59 into hours, and hours wrap from 23 to 00.
- R3: When hours wrap, the day code steps from 0 to 6 and then back to 0, and the date advances. The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. A date wrap advances the month, and month 12 wraps to 01.
- R4: February ends on day 29 when the two low year digits form a multiple of 4, and on day 28 otherwise. The year counts as four BCD digits and carries 1999 to 2000 and 2099 to 2100.
- R5: Writing 1 to bit 0 of location F requests a round. If seconds are 00 to 29 when the round executes, seconds become 00 and minutes are unchanged.
- R6: If seconds are 30 to 59 when the round executes, seconds become 00 and minutes advance by one with the normal carries into hours and the date.
- R7: A pending round executes on the first `tick_4k` strobe after it is accepted. The request then clears itself and the divider restarts from zero, with no seconds advance on that strobe. Writing 0 to bit 0 of location F has no effect.
- R8: The `busy` output and bit 0 of location F are 1 in two cases. The first is while the divider sits in its final slot before a seconds advance, with stop at 0. The second is while a round is pending.
- R9: Bit 1 of location F is stop. While it is 1 the divider stays cleared and no digit advances. After it is cleared, the next seconds advance comes after a full `TICKS_PER_SEC` strobes.
- R10: A write to locations 0 to E replaces that digit on the next clock edge and takes priority over any advance of that digit in the same cycle. The other digits still update normally. The address map is: 0/1 seconds units/tens (3 bits), 2/3 minutes units/tens (3 bits), 4/5 hours units/tens (2 bits), 6 day code (3 bits), 7/8 date units/tens (2 bits), 9/A month units/tens (1 bit), B/C/D/E year units/tens/hundreds/thousands.
- R11: `rd_data` presents the value of location `rd_addr` as it was before the clock edge, one cycle after the address. Unused high bits read 0, and location F reads `{0, 0, stop, busy}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_4k | input | 1 | One-cycle strobe at the 4096 Hz rate |
| wr_en | input | 1 | Write strobe for one nibble location |
| wr_addr | input | 4 | Location to write |
| wr_data | input | 4 | Nibble to write |
| rd_addr | input | 4 | Location to read |
| rd_data | output | 4 | Registered read nibble |
| busy | output | 1 | Update-in-progress warning |

## Verification
Most internal faults surface at the ports within one seconds period.

- A divider that counts wrongly moves the `busy` window and the seconds advance off their expected strobe.
- A faulty carry or month-length entry corrupts a digit that the sweeping read port exposes within sixteen cycles of the rollover.
- A rounding request that is lost or fires late shows as a `busy` level that stays wrong on the very next cycle.
- A wrong stop behaviour shows as seconds that change while frozen, or a first advance that arrives after the wrong number of strobes.

The reference model follows every digit on every cycle. Any such divergence is therefore caught on the cycle where the read port or `busy` first differs.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef logic [3:0] nib_t;

  localparam int YEAR_DIGITS = 4;

  localparam logic [3:0] AD_SEC_U = 4'h0;
  localparam logic [3:0] AD_SEC_T = 4'h1;
  localparam logic [3:0] AD_MIN_U = 4'h2;
  localparam logic [3:0] AD_MIN_T = 4'h3;
  localparam logic [3:0] AD_HR_U  = 4'h4;
  localparam logic [3:0] AD_HR_T  = 4'h5;
  localparam logic [3:0] AD_DOW   = 4'h6;
  localparam logic [3:0] AD_DAY_U = 4'h7;
  localparam logic [3:0] AD_DAY_T = 4'h8;
  localparam logic [3:0] AD_MON_U = 4'h9;
  localparam logic [3:0] AD_MON_T = 4'hA;
  localparam logic [3:0] AD_YR_U  = 4'hB;
  localparam logic [3:0] AD_YR_T  = 4'hC;
  localparam logic [3:0] AD_YR_H  = 4'hD;
  localparam logic [3:0] AD_YR_K  = 4'hE;
  localparam logic [3:0] AD_CTRL  = 4'hF;

  localparam int CTRL_ADJ_BIT  = 0;
  localparam int CTRL_STOP_BIT = 1;

  // reset calendar: 2000-01-01, day code 6
  localparam logic [15:0] YEAR_RST = 16'h2000;
  localparam logic [2:0]  DOW_RST  = 3'd6;

  function automatic nib_t unit_inc(nib_t u);
    return (u == 4'd9) ? 4'd0 : nib_t'(u + 4'd1);
  endfunction

  // year is leap when its low two BCD digits form a multiple of 4
  function automatic logic leap_year(nib_t tens, nib_t units);
    if (tens[0]) return (units == 4'd2) || (units == 4'd6);
    else         return (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
  endfunction

  // last day of month as {tens[1:0], units[3:0]} in BCD
  function automatic logic [5:0] month_last_day(logic mon_t, nib_t mon_u, logic leap);
    if (mon_t) return (mon_u == 4'd1) ? 6'h30 : 6'h31;
    case (mon_u)
      4'd2:                return leap ? 6'h29 : 6'h28;
      4'd4, 4'd6, 4'd9:    return 6'h30;
      default:             return 6'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic stop,
  input  logic adj_fire,
  output logic sec_pulse,
  output logic last_slot
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (stop || adj_fire) cnt_q <= '0;
    else if (tick)           cnt_q <= (cnt_q == LAST) ? '0 : CW'(cnt_q + 1'b1);
  end

  assign last_slot = (cnt_q == LAST) && !stop;
  assign sec_pulse = tick && last_slot && !adj_fire;

  // R9: a stopped divider never leaves zero
  p_div_parked_r9: assert property (@(posedge clk) disable iff (rst)
    stop |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sec_pulse,
  input  logic       adj_fire,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  output logic [3:0] sec_u,
  output logic [2:0] sec_t,
  output logic [3:0] min_u,
  output logic [2:0] min_t,
  output logic [3:0] hr_u,
  output logic [1:0] hr_t,
  output logic       day_carry
);
  logic sec_wrap, min_wrap, hr_wrap, min_adv, hr_adv;
  logic wr_sec, wr_min;

  assign sec_wrap  = (sec_t == 3'd5) && (sec_u == 4'd9);
  assign min_wrap  = (min_t == 3'd5) && (min_u == 4'd9);
  assign hr_wrap   = (hr_t  == 2'd2) && (hr_u  == 4'd3);
  assign min_adv   = adj_fire ? (sec_t >= 3'd3) : (sec_pulse && sec_wrap);
  assign hr_adv    = min_adv && min_wrap;
  assign day_carry = hr_adv && hr_wrap;
  assign wr_sec    = wr_en && ((wr_addr == AD_SEC_U) || (wr_addr == AD_SEC_T));
  assign wr_min    = wr_en && ((wr_addr == AD_MIN_U) || (wr_addr == AD_MIN_T));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_u <= '0;
      sec_t <= '0;
    end else begin
      if (adj_fire) begin
        sec_u <= '0;
        sec_t <= '0;
      end else if (sec_pulse) begin
        sec_u <= unit_inc(sec_u);
        if (sec_u == 4'd9) sec_t <= sec_wrap ? 3'd0 : 3'(sec_t + 3'd1);
      end
      if (wr_en && wr_addr == AD_SEC_U) sec_u <= wr_data;
      if (wr_en && wr_addr == AD_SEC_T) sec_t <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      min_u <= '0;
      min_t <= '0;
    end else begin
      if (min_adv) begin
        min_u <= unit_inc(min_u);
        if (min_u == 4'd9) min_t <= min_wrap ? 3'd0 : 3'(min_t + 3'd1);
      end
      if (wr_en && wr_addr == AD_MIN_U) min_u <= wr_data;
      if (wr_en && wr_addr == AD_MIN_T) min_t <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_u <= '0;
      hr_t <= '0;
    end else begin
      if (hr_adv) begin
        if (hr_wrap) begin
          hr_u <= '0;
          hr_t <= '0;
        end else begin
          hr_u <= unit_inc(hr_u);
          if (hr_u == 4'd9) hr_t <= 2'(hr_t + 2'd1);
        end
      end
      if (wr_en && wr_addr == AD_HR_U) hr_u <= wr_data;
      if (wr_en && wr_addr == AD_HR_T) hr_t <= wr_data[1:0];
    end
  end

  // R2: seconds only move on a pulse, a round or a write
  p_sec_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!sec_pulse && !adj_fire && !wr_sec) |=> ($stable(sec_u) && $stable(sec_t)));

  // R5: an executed round leaves seconds at 00
  p_round_zeroes_sec_r5: assert property (@(posedge clk) disable iff (rst)
    (adj_fire && !wr_sec) |=> (sec_u == 4'd0 && sec_t == 3'd0));

  // R5: rounding down keeps minutes
  p_round_down_keeps_min_r5: assert property (@(posedge clk) disable iff (rst)
    (adj_fire && sec_t < 3'd3 && !wr_min) |=> ($stable(min_u) && $stable(min_t)));

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        day_carry,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [3:0]  wr_data,
  output logic [2:0]  dow,
  output logic [3:0]  day_u,
  output logic [1:0]  day_t,
  output logic [3:0]  mon_u,
  output logic        mon_t,
  output logic [15:0] year_bcd
);
  logic       leap, day_wrap, mon_adv, mon_wrap;
  logic [5:0] last_day;
  logic [3:0] yr_q [YEAR_DIGITS];
  logic [YEAR_DIGITS-1:0] ycar;

  assign leap     = leap_year(yr_q[1], yr_q[0]);
  assign last_day = month_last_day(mon_t, mon_u, leap);
  assign day_wrap = ({day_t, day_u} == last_day);
  assign mon_adv  = day_carry && day_wrap;
  assign mon_wrap = mon_t && (mon_u == 4'd2);

  always_ff @(posedge clk) begin
    if (rst) dow <= DOW_RST;
    else begin
      if (day_carry) dow <= (dow == 3'd6) ? 3'd0 : 3'(dow + 3'd1);
      if (wr_en && wr_addr == AD_DOW) dow <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      day_u <= 4'd1;
      day_t <= 2'd0;
    end else begin
      if (day_carry) begin
        if (day_wrap) begin
          day_u <= 4'd1;
          day_t <= 2'd0;
        end else begin
          day_u <= unit_inc(day_u);
          if (day_u == 4'd9) day_t <= 2'(day_t + 2'd1);
        end
      end
      if (wr_en && wr_addr == AD_DAY_U) day_u <= wr_data;
      if (wr_en && wr_addr == AD_DAY_T) day_t <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_u <= 4'd1;
      mon_t <= 1'b0;
    end else begin
      if (mon_adv) begin
        if (mon_wrap) begin
          mon_u <= 4'd1;
          mon_t <= 1'b0;
        end else begin
          mon_u <= unit_inc(mon_u);
          if (mon_u == 4'd9) mon_t <= 1'b1;
        end
      end
      if (wr_en && wr_addr == AD_MON_U) mon_u <= wr_data;
      if (wr_en && wr_addr == AD_MON_T) mon_t <= wr_data[0];
    end
  end

  for (genvar gi = 0; gi < YEAR_DIGITS; gi++) begin : g_year
    if (gi == 0) begin : g_first
      assign ycar[gi] = mon_adv && mon_wrap;
    end else begin : g_rest
      assign ycar[gi] = ycar[gi-1] && (yr_q[gi-1] == 4'd9);
    end

    always_ff @(posedge clk) begin
      if (rst) yr_q[gi] <= YEAR_RST[4*gi +: 4];
      else begin
        if (ycar[gi]) yr_q[gi] <= unit_inc(yr_q[gi]);
        if (wr_en && wr_addr == 4'(AD_YR_U + gi)) yr_q[gi] <= wr_data;
      end
    end

    assign year_bcd[4*gi +: 4] = yr_q[gi];
  end

  // R4: 28 February of a leap year rolls to 29 February
  p_leap_day_r4: assert property (@(posedge clk) disable iff (rst)
    (day_carry && leap && !mon_t && mon_u == 4'd2 && day_t == 2'd2 && day_u == 4'd8 && !wr_en)
    |=> (day_t == 2'd2 && day_u == 4'd9 && mon_u == 4'd2));

  // R3: the day code never leaves 0..6 on its own
  p_dow_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (day_carry && dow == 3'd6 && !wr_en) |=> (dow == 3'd0));

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4096
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_4k,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [3:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [3:0] rd_data,
  output logic       busy
);
  logic stop_q, adj_pend_q, adj_fire, ctrl_wr;
  logic sec_pulse, last_slot, day_carry;
  logic [3:0]  sec_u, min_u, hr_u, day_u, mon_u;
  logic [2:0]  sec_t, min_t, dow;
  logic [1:0]  hr_t, day_t;
  logic        mon_t;
  logic [15:0] year_bcd;
  logic [3:0]  rd_next;

  assign ctrl_wr  = wr_en && (wr_addr == AD_CTRL);
  assign adj_fire = adj_pend_q && tick_4k;
  assign busy     = adj_pend_q || last_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q     <= 1'b0;
      adj_pend_q <= 1'b0;
    end else begin
      if (ctrl_wr) stop_q <= wr_data[CTRL_STOP_BIT];
      if (ctrl_wr && wr_data[CTRL_ADJ_BIT]) adj_pend_q <= 1'b1;
      else if (adj_fire)                    adj_pend_q <= 1'b0;
    end
  end

  rtc_subsec_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_4k),
    .stop      (stop_q),
    .adj_fire  (adj_fire),
    .sec_pulse (sec_pulse),
    .last_slot (last_slot)
  );

  rtc_time_chain u_time (
    .clk       (clk),
    .rst       (rst),
    .sec_pulse (sec_pulse),
    .adj_fire  (adj_fire),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sec_u     (sec_u),
    .sec_t     (sec_t),
    .min_u     (min_u),
    .min_t     (min_t),
    .hr_u      (hr_u),
    .hr_t      (hr_t),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .clk       (clk),
    .rst       (rst),
    .day_carry (day_carry),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dow       (dow),
    .day_u     (day_u),
    .day_t     (day_t),
    .mon_u     (mon_u),
    .mon_t     (mon_t),
    .year_bcd  (year_bcd)
  );

  always_comb begin
    case (rd_addr)
      AD_SEC_U: rd_next = sec_u;
      AD_SEC_T: rd_next = {1'b0, sec_t};
      AD_MIN_U: rd_next = min_u;
      AD_MIN_T: rd_next = {1'b0, min_t};
      AD_HR_U:  rd_next = hr_u;
      AD_HR_T:  rd_next = {2'b00, hr_t};
      AD_DOW:   rd_next = {1'b0, dow};
      AD_DAY_U: rd_next = day_u;
      AD_DAY_T: rd_next = {2'b00, day_t};
      AD_MON_U: rd_next = mon_u;
      AD_MON_T: rd_next = {3'b000, mon_t};
      AD_YR_U:  rd_next = year_bcd[3:0];
      AD_YR_T:  rd_next = year_bcd[7:4];
      AD_YR_H:  rd_next = year_bcd[11:8];
      AD_YR_K:  rd_next = year_bcd[15:12];
      default:  rd_next = {2'b00, stop_q, busy};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  // R8: every seconds advance is preceded by a busy cycle
  p_busy_leads_update_r8: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> busy);

  // R7: a write of 0 to the round bit raises no request
  p_round_zero_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !wr_data[CTRL_ADJ_BIT] && !adj_pend_q) |=> !adj_pend_q);

  // R7: a request clears itself on the strobe that executes it
  p_round_self_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (adj_fire && !ctrl_wr) |=> !adj_pend_q);

  // R9: frozen time does not move
  p_stop_freezes_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !wr_en && !adj_pend_q) |=> ($stable(sec_u) && $stable(sec_t) && $stable(min_u)));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_4k = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [3:0] rd_data;
  logic busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_calendar #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk(clk), .rst(rst), .tick_4k(tick_4k), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  // behavioural reference state
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_year, m_div;
  bit m_stop, m_adj;
  int exp_rd, last_addr;
  bit exp_busy, seen, done;
  int vectors = 0, fails = 0;
  string cur_req = "R1";

  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit m_busy();
    return m_adj || (m_div == TPS-1 && !m_stop);
  endfunction

  function automatic int field(int a);
    case (a)
      0: return m_sec % 10;   1: return m_sec / 10;
      2: return m_min % 10;   3: return m_min / 10;
      4: return m_hr % 10;    5: return m_hr / 10;
      6: return m_dow;
      7: return m_date % 10;  8: return m_date / 10;
      9: return m_mon % 10;   10: return m_mon / 10;
      11: return m_year % 10; 12: return (m_year / 10) % 10;
      13: return (m_year / 100) % 10; 14: return m_year / 1000;
      default: return (m_stop ? 2 : 0) + (m_busy() ? 1 : 0);
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 6; m_date = 1; m_mon = 1;
    m_year = 2000; m_div = 0; m_stop = 0; m_adj = 0;
  endtask

  task automatic model_step();
    bit fire, pulse, min_adv, hr_adv, day_adv, mon_adv;
    int a, d;
    fire  = m_adj && tick_4k;
    pulse = tick_4k && !m_stop && !fire && (m_div == TPS-1);
    min_adv = fire ? (m_sec >= 30) : (pulse && m_sec == 59);
    hr_adv  = min_adv && m_min == 59;
    day_adv = hr_adv && m_hr == 23;
    mon_adv = day_adv && m_date == mlen(m_mon, m_year);
    if (fire) m_sec = 0; else if (pulse) m_sec = (m_sec + 1) % 60;
    if (min_adv) m_min = (m_min + 1) % 60;
    if (hr_adv)  m_hr = (m_hr + 1) % 24;
    if (day_adv) begin
      m_dow = (m_dow + 1) % 7;
      m_date = mon_adv ? 1 : m_date + 1;
    end
    if (mon_adv) begin
      if (m_mon == 12) begin m_mon = 1; m_year = (m_year + 1) % 10000; end
      else m_mon = m_mon + 1;
    end
    if (m_stop || fire) m_div = 0;
    else if (tick_4k) m_div = (m_div == TPS-1) ? 0 : m_div + 1;
    if (wr_en) begin
      a = int'(wr_addr); d = int'(wr_data);
      case (a)
        0: m_sec = (m_sec / 10) * 10 + d;
        1: m_sec = (d % 8) * 10 + m_sec % 10;
        2: m_min = (m_min / 10) * 10 + d;
        3: m_min = (d % 8) * 10 + m_min % 10;
        4: m_hr = (m_hr / 10) * 10 + d;
        5: m_hr = (d % 4) * 10 + m_hr % 10;
        6: m_dow = d % 8;
        7: m_date = (m_date / 10) * 10 + d;
        8: m_date = (d % 4) * 10 + m_date % 10;
        9: m_mon = (m_mon / 10) * 10 + d;
        10: m_mon = (d % 2) * 10 + m_mon % 10;
        11: m_year = (m_year / 10) * 10 + d;
        12: m_year = (m_year / 100) * 100 + d * 10 + m_year % 10;
        13: m_year = (m_year / 1000) * 1000 + d * 100 + m_year % 100;
        14: m_year = d * 1000 + m_year % 1000;
        default: begin
          m_stop = wr_data[1];
          if (wr_data[0]) m_adj = 1;
          else if (fire) m_adj = 0;
        end
      endcase
      if (a != 15 && fire) m_adj = 0;
    end else if (fire) m_adj = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
      exp_rd = 0;
    end else begin
      exp_rd = field(int'(rd_addr));
      model_step();
    end
    last_addr = int'(rd_addr);
    exp_busy = m_busy();
    seen = 1;
  end

  always @(negedge clk) begin
    if (seen && !done) begin
      vectors++;
      if (rd_data !== exp_rd[3:0]) begin
        fails++;
        $display("FAIL %s: rd_data at location %0h got %h expected %h (t=%0t)",
                 cur_req, last_addr, rd_data, exp_rd[3:0], $time);
      end
      if (busy !== exp_busy) begin
        fails++;
        $display("FAIL %s: busy got %b expected %b (t=%0t)", cur_req, busy, exp_busy, $time);
      end
      rd_addr <= rd_addr + 4'd1;
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); tick_4k = 0; wr_en = 0; end
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wr_en = 0;
      tick_4k = (gap == 0) || (i % gap == 0);
    end
  endtask

  task automatic wr(int a, int d, bit tk);
    @(negedge clk); tick_4k = tk; wr_en = 1; wr_addr = a[3:0]; wr_data = d[3:0];
    @(negedge clk); wr_en = 0; tick_4k = 0;
  endtask

  task automatic set_time(int h, int m, int s);
    wr(0, s % 10, 0); wr(1, s / 10, 0);
    wr(2, m % 10, 0); wr(3, m / 10, 0);
    wr(4, h % 10, 0); wr(5, h / 10, 0);
  endtask

  task automatic set_date(int y, int mo, int d, int dw);
    wr(7, d % 10, 0); wr(8, d / 10, 0);
    wr(9, mo % 10, 0); wr(10, mo / 10, 0);
    wr(11, y % 10, 0); wr(12, (y / 10) % 10, 0);
    wr(13, (y / 100) % 10, 0); wr(14, y / 1000, 0);
    wr(6, dw, 0);
  endtask

  task automatic sweep();
    idle(20);   // every location passes the read port
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1"; sweep();

    cur_req = "R2"; run(TPS * 70, 0); sweep();
    run(TPS * 5 * 3, 3); sweep();
    set_time(23, 59, 50); run(TPS * 14, 0); sweep();

    cur_req = "R3"; set_date(2023, 4, 30, 6); set_time(23, 59, 58); run(TPS * 3, 0); sweep();
    set_date(2023, 11, 30, 3); set_time(23, 59, 59); run(TPS * 2, 0); sweep();
    set_date(2023, 1, 31, 2); set_time(23, 59, 59); run(TPS * 2, 0); sweep();

    cur_req = "R4"; set_date(2023, 2, 28, 2); set_time(23, 59, 59); run(TPS * 2, 0); sweep();
    set_date(2024, 2, 28, 3); set_time(23, 59, 59); run(TPS * 2, 0); sweep();
    set_time(23, 59, 59); run(TPS * 2, 0); sweep();
    set_date(1999, 12, 31, 5); set_time(23, 59, 59); run(TPS * 2, 0); sweep();
    set_date(2099, 12, 31, 4); set_time(23, 59, 58); run(TPS * 3, 0); sweep();

    cur_req = "R5"; set_time(10, 20, 29); wr(15, 1, 0); run(1, 0); sweep();
    set_time(10, 20, 0); wr(15, 1, 1); sweep();

    cur_req = "R6"; set_time(23, 59, 45); wr(15, 1, 0); run(1, 0); sweep();
    set_time(4, 17, 30); wr(15, 1, 0); run(TPS + 2, 0); sweep();

    cur_req = "R7"; set_time(5, 5, 44); wr(15, 1, 0); idle(9); run(1, 0); sweep();
    wr(15, 0, 0); idle(5); run(TPS * 2, 0); sweep();

    cur_req = "R8"; run(TPS * 3, 2); sweep();

    cur_req = "R9"; wr(15, 2, 0); run(TPS * 6, 0); sweep();
    wr(15, 3, 0); run(2, 0); sweep();
    wr(15, 0, 0); run(TPS * 4 + 3, 0); sweep();

    cur_req = "R10"; set_time(1, 2, 59); run(TPS - 1, 0); wr(0, 7, 1); sweep();
    run(TPS - 1, 0); wr(2, 4, 1); run(TPS * 2, 0); sweep();

    cur_req = "R11"; run(TPS * 3, 0); sweep();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule